// File: doc/BRIEF.md
# Jump, Call and Return Sequencer

This block owns the instruction pointer, the stack pointer and the flags word of a core that runs in one flat code space, and it computes where execution continues after an unconditional transfer. A decoder hands it one operation at a time: a relative jump, a jump through a register or a memory-supplied pointer, the three matching call forms, a plain return or a return from interrupt. Relative forms add a signed displacement of one, two or four bytes to the address of the next instruction. Calls save that next address on a downward-growing stack. Returns restore it, optionally releasing caller arguments. The interrupt return also restores the flags word.

Operations arrive on a valid/ready channel. `op_ready` is high only while the sequencer is idle, and an operation is taken on a cycle where `op_valid` and `op_ready` are both high; the decoder must hold the operation fields stable until then. The stack is reached through a one-word request channel. A request (`stk_valid`, `stk_write`, `stk_addr`, `stk_wdata`) stays unchanged until the memory raises `stk_ready`. For reads the memory must present `stk_rdata` in that same handshake cycle. Every completed operation is signalled by a one-cycle `done` pulse, which is high in the cycle after the final register update, together with the new values.

Top module: `xfer_seq`

## Requirements
- R1: After reset, `ip` equals RESET_IP, `sp` equals RESET_SP and `flags` equals RESET_FLAGS. `op_ready` is 1, and `stk_valid` and `done` are 0.
- R2: An operation is accepted only when `op_valid` and `op_ready` are both high. `op_ready` is low from acceptance of a stack-using operation until it completes, and `op_valid` is ignored during that time. `done` is high for exactly the one cycle after each operation's last update.
- R3: The relative jump (`op_kind`=0) sets `ip` to `ip + insn_len + ext(disp)`. The displacement width is chosen by `disp_size`: 0 sign-extends bits 7:0, 1 sign-extends bits 15:0, and 2 or 3 use all 32 bits. Higher unused bits are ignored. `done` follows one cycle after acceptance.
- R4: The register jump (`op_kind`=1) loads `reg_target` and the memory-pointer jump (`op_kind`=2) loads `mem_target`. No jump makes a stack request or changes `sp`.
- R5: A call (`op_kind` 3 = relative, 4 = register, 5 = memory-pointer, with the targets chosen as in R3/R4) makes one write of `ip + insn_len` at address `sp - 4`. At that write's handshake, `sp` drops by 4 and `ip` takes the target.
- R6: A return (`op_kind`=6) makes one read at address `sp`. At its handshake, `ip` takes the word read, and `sp` becomes `sp + 4 + ret_pop`, with `ret_pop` zero-extended.
- R7: An interrupt return (`op_kind`=7) makes two reads. The first, at `sp`, loads `ip`. The second, at the original `sp + 4`, loads `flags`. In total `sp` rises by 8, and `ret_pop` is ignored. `flags` changes at no other time.
- R8: While `stk_valid` is high and `stk_ready` is low, the request fields hold their values and `ip`, `sp` and `flags` do not change.
- R9: Address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Sequencer idle, operation can be taken |
| op_kind | input | 3 | Operation code (see R3 to R7) |
| disp_size | input | 2 | Displacement width select |
| disp | input | 32 | Raw displacement |
| reg_target | input | 32 | Absolute target from a register |
| mem_target | input | 32 | Absolute target fetched from memory |
| insn_len | input | 4 | Length of the current instruction in bytes |
| ret_pop | input | 16 | Extra bytes released by a return |
| stk_valid | output | 1 | Stack request pending |
| stk_ready | input | 1 | Stack memory accepts the request |
| stk_write | output | 1 | 1 = write, 0 = read |
| stk_addr | output | 32 | Byte address of the stack word |
| stk_wdata | output | 32 | Word to write |
| stk_rdata | input | 32 | Word read, valid in the handshake cycle |
| ip | output | 32 | Instruction pointer |
| sp | output | 32 | Stack pointer |
| flags | output | 32 | Flags word |
| done | output | 1 | Operation complete pulse |

## Verification
A jump completes in the cycle right after it is taken. A call or a return needs one extra cycle per stack access, and one more for each cycle `stk_ready` is held low. With an always-ready memory, a call or return therefore reports `done` two cycles after acceptance and an interrupt return three. The bench samples on the falling edge. It counts those edges from acceptance until `done` and compares the count with these figures. It reads `ip`, `sp` and `flags` on the same edge where `done` is first seen. During a forced stall it checks each falling edge for a frozen request and frozen registers.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    OP_JREL = 3'd0,
    OP_JREG = 3'd1,
    OP_JMEM = 3'd2,
    OP_CREL = 3'd3,
    OP_CREG = 3'd4,
    OP_CMEM = 3'd5,
    OP_RET  = 3'd6,
    OP_IRET = 3'd7
  } xfer_op_e;

  typedef enum logic [1:0] {
    DSZ_BYTE  = 2'd0,
    DSZ_HALF  = 2'd1,
    DSZ_WORD  = 2'd2,
    DSZ_WORD2 = 2'd3
  } disp_sz_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP_IP,
    ST_POP_FL
  } seq_state_e;

  function automatic logic is_call(xfer_op_e op);
    return (op == OP_CREL) || (op == OP_CREG) || (op == OP_CMEM);
  endfunction

  function automatic logic is_jump(xfer_op_e op);
    return (op == OP_JREL) || (op == OP_JREG) || (op == OP_JMEM);
  endfunction

endpackage

// File: rtl/xfer_target.sv
module xfer_target
  import xfer_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 4
) (
  input  logic [2:0]       op_kind,
  input  logic [1:0]       disp_size,
  input  logic [AW-1:0]    disp,
  input  logic [AW-1:0]    reg_target,
  input  logic [AW-1:0]    mem_target,
  input  logic [LEN_W-1:0] insn_len,
  input  logic [AW-1:0]    ip,
  output logic [AW-1:0]    next_ip,
  output logic [AW-1:0]    target
);

  localparam int N_SZ = 3;

  logic [AW-1:0] ext [N_SZ];
  logic [AW-1:0] rel_disp;
  xfer_op_e      op;

  // one sign-extended candidate per displacement width: 8, 16, 32 bits
  for (genvar g = 0; g < N_SZ; g++) begin : g_ext
    localparam int SW = 8 << g;
    assign ext[g] = AW'($signed(disp[SW-1:0]));
  end

  always_comb begin
    unique case (disp_sz_e'(disp_size))
      DSZ_BYTE: rel_disp = ext[0];
      DSZ_HALF: rel_disp = ext[1];
      default:  rel_disp = ext[2];
    endcase
  end

  assign op      = xfer_op_e'(op_kind);
  assign next_ip = ip + AW'(insn_len);

  always_comb begin
    unique case (op)
      OP_JREL, OP_CREL: target = next_ip + rel_disp;
      OP_JREG, OP_CREG: target = reg_target;
      default:          target = mem_target;
    endcase
  end

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int          AW          = 32,
  parameter int          IMM_W       = 16,
  parameter logic [AW-1:0] RESET_IP    = 32'h0000_1000,
  parameter logic [AW-1:0] RESET_SP    = 32'h0000_0100,
  parameter logic [AW-1:0] RESET_FLAGS = 32'h0000_0002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [2:0]       op_kind,
  input  logic [IMM_W-1:0] ret_pop,
  input  logic [AW-1:0]    next_ip,
  input  logic [AW-1:0]    target,
  output logic             stk_valid,
  input  logic             stk_ready,
  output logic             stk_write,
  output logic [AW-1:0]    stk_addr,
  output logic [AW-1:0]    stk_wdata,
  input  logic [AW-1:0]    stk_rdata,
  output logic [AW-1:0]    ip,
  output logic [AW-1:0]    sp,
  output logic [AW-1:0]    flags,
  output logic             done
);

  localparam logic [AW-1:0] WORD_B = AW'(AW / 8);

  seq_state_e       state_q;
  logic [AW-1:0]    ip_q, sp_q, flags_q;
  logic [AW-1:0]    ret_q, tgt_q;
  logic [IMM_W-1:0] pop_q;
  logic             iret_q;
  logic             done_q;
  logic             hs;
  xfer_op_e         op;

  assign op        = xfer_op_e'(op_kind);
  assign op_ready  = (state_q == ST_IDLE);
  assign stk_valid = (state_q != ST_IDLE);
  assign stk_write = (state_q == ST_PUSH);
  assign stk_addr  = (state_q == ST_PUSH) ? sp_q - WORD_B : sp_q;
  assign stk_wdata = ret_q;
  assign hs        = stk_valid && stk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ip_q    <= RESET_IP;
      sp_q    <= RESET_SP;
      flags_q <= RESET_FLAGS;
      ret_q   <= '0;
      tgt_q   <= '0;
      pop_q   <= '0;
      iret_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (op_valid) begin
            if (is_jump(op)) begin
              ip_q   <= target;
              done_q <= 1'b1;
            end else if (is_call(op)) begin
              ret_q   <= next_ip;
              tgt_q   <= target;
              state_q <= ST_PUSH;
            end else begin
              iret_q  <= (op == OP_IRET);
              pop_q   <= (op == OP_IRET) ? '0 : ret_pop;
              state_q <= ST_POP_IP;
            end
          end
        end
        ST_PUSH: begin
          if (hs) begin
            sp_q    <= sp_q - WORD_B;
            ip_q    <= tgt_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_POP_IP: begin
          if (hs) begin
            ip_q <= stk_rdata;
            if (iret_q) begin
              sp_q    <= sp_q + WORD_B;
              state_q <= ST_POP_FL;
            end else begin
              sp_q    <= sp_q + WORD_B + AW'(pop_q);
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_POP_FL: begin
          if (hs) begin
            flags_q <= stk_rdata;
            sp_q    <= sp_q + WORD_B;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ip    = ip_q;
  assign sp    = sp_q;
  assign flags = flags_q;
  assign done  = done_q;

  // R8: a stalled request holds its fields
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_addr) &&
                                   $stable(stk_write) && $stable(stk_wdata)));

  // R8: architectural state frozen during a stall
  assert_state_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> ($stable(ip_q) && $stable(sp_q) && $stable(flags_q)));

  // R7: flags move only on a completed stack read
  assert_flags_only_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_valid && stk_ready && !stk_write) |=> $stable(flags_q));

  // R4: jumps finish next cycle without stack traffic
  assert_jump_no_stack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && is_jump(op)) |=> (done && !stk_valid && $stable(sp_q)));

  // R5: a completed push lowers sp by one word and signals done
  assert_push_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && stk_ready && stk_write) |=> (done && sp_q == $past(sp_q) - WORD_B));

  // R6: first pop loads the word read into ip
  assert_pop_ip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && state_q == ST_POP_IP) |=> (ip_q == $past(stk_rdata)));

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int            AW          = 32,
  parameter int            LEN_W       = 4,
  parameter int            IMM_W       = 16,
  parameter logic [AW-1:0] RESET_IP    = 32'h0000_1000,
  parameter logic [AW-1:0] RESET_SP    = 32'h0000_0100,
  parameter logic [AW-1:0] RESET_FLAGS = 32'h0000_0002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [2:0]       op_kind,
  input  logic [1:0]       disp_size,
  input  logic [AW-1:0]    disp,
  input  logic [AW-1:0]    reg_target,
  input  logic [AW-1:0]    mem_target,
  input  logic [LEN_W-1:0] insn_len,
  input  logic [IMM_W-1:0] ret_pop,
  output logic             stk_valid,
  input  logic             stk_ready,
  output logic             stk_write,
  output logic [AW-1:0]    stk_addr,
  output logic [AW-1:0]    stk_wdata,
  input  logic [AW-1:0]    stk_rdata,
  output logic [AW-1:0]    ip,
  output logic [AW-1:0]    sp,
  output logic [AW-1:0]    flags,
  output logic             done
);

  logic [AW-1:0] next_ip, target;

  xfer_target #(.AW(AW), .LEN_W(LEN_W)) u_target (
    .op_kind    (op_kind),
    .disp_size  (disp_size),
    .disp       (disp),
    .reg_target (reg_target),
    .mem_target (mem_target),
    .insn_len   (insn_len),
    .ip         (ip),
    .next_ip    (next_ip),
    .target     (target)
  );

  xfer_ctrl #(
    .AW(AW), .IMM_W(IMM_W),
    .RESET_IP(RESET_IP), .RESET_SP(RESET_SP), .RESET_FLAGS(RESET_FLAGS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_kind   (op_kind),
    .ret_pop   (ret_pop),
    .next_ip   (next_ip),
    .target    (target),
    .stk_valid (stk_valid),
    .stk_ready (stk_ready),
    .stk_write (stk_write),
    .stk_addr  (stk_addr),
    .stk_wdata (stk_wdata),
    .stk_rdata (stk_rdata),
    .ip        (ip),
    .sp        (sp),
    .flags     (flags),
    .done      (done)
  );

endmodule

// File: tb/xfer_seq_test.sv
module xfer_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_kind = '0;
  logic [1:0]  disp_size = '0;
  logic [31:0] disp = '0, reg_target = '0, mem_target = '0;
  logic [3:0]  insn_len = '0;
  logic [15:0] ret_pop = '0;
  logic        stk_valid, stk_ready, stk_write;
  logic [31:0] stk_addr, stk_wdata, stk_rdata;
  logic [31:0] ip, sp, flags;
  logic        done;

  int errors = 0;
  int checks = 0;
  int stall_set = 0;
  int wait_cnt = 0;
  int cycles = 0;

  logic [31:0] smem [0:63];
  logic        poke_en = 1'b0;
  logic [31:0] poke_addr = '0, poke_data = '0;

  always #2.5 clk = ~clk;

  xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .disp_size(disp_size), .disp(disp),
    .reg_target(reg_target), .mem_target(mem_target), .insn_len(insn_len),
    .ret_pop(ret_pop), .stk_valid(stk_valid), .stk_ready(stk_ready),
    .stk_write(stk_write), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .stk_rdata(stk_rdata), .ip(ip), .sp(sp), .flags(flags), .done(done)
  );

  // stack memory model: ready after stall_set waiting cycles
  assign stk_ready = (wait_cnt >= stall_set);
  assign stk_rdata = smem[stk_addr[7:2]];

  always @(posedge clk) begin
    if (poke_en) smem[poke_addr[7:2]] <= poke_data;
    if (stk_valid && stk_ready) begin
      wait_cnt <= 0;
      if (stk_write) smem[stk_addr[7:2]] <= stk_wdata;
    end else if (stk_valid) begin
      wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  // offer one op, return falling edges from acceptance until done
  task automatic issue(input logic [2:0] k, input logic [1:0] ds, input logic [31:0] d,
                       input logic [31:0] rt, input logic [31:0] mt,
                       input logic [3:0] len, input logic [15:0] pop, output int lat);
    @(negedge clk);
    op_kind = k; disp_size = ds; disp = d; reg_target = rt; mem_target = mt;
    insn_len = len; ret_pop = pop; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    lat = 1;
    while (done !== 1'b1 && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic logic [31:0] sx(input logic [1:0] ds, input logic [31:0] d);
    if (ds == 2'd0) return {{24{d[7]}}, d[7:0]};
    if (ds == 2'd1) return {{16{d[15]}}, d[15:0]};
    return d;
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ip", ip, 32'h1000);
    chk("R1 sp", sp, 32'h100);
    chk("R1 flags", flags, 32'h2);
    chk("R1 op_ready", {31'd0, op_ready}, 32'd1);
    chk("R1 stk_valid", {31'd0, stk_valid}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_rel_jumps;
    int lat;
    logic [31:0] e;
    for (int s = 0; s < 4; s++) begin
      logic [31:0] d;
      d = (s == 0) ? 32'h1234_56F0 : (s == 1) ? 32'hABCD_0100 :
          (s == 2) ? 32'hFFFF_0000 : 32'h0001_0040;
      e = ip + 32'd3 + sx(2'(s), d);
      issue(3'd0, 2'(s), d, '0, '0, 4'd3, '0, lat);
      chk("R3 relative target", ip, e);
      chk("R2 R3 jump latency", lat, 1);
      chk("R4 jump keeps sp", sp, 32'h100);
    end
    @(negedge clk);
    chk("R2 done single cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_indirect;
    int lat;
    issue(3'd1, 2'd0, 32'h55, 32'h0000_2000, 32'h0000_3000, 4'd2, '0, lat);
    chk("R4 register jump", ip, 32'h2000);
    chk("R4 register jump sp", sp, 32'h100);
    issue(3'd2, 2'd0, 32'h55, 32'h0000_2000, 32'h0000_3000, 4'd2, '0, lat);
    chk("R4 memory jump", ip, 32'h3000);
    chk("R4 memory jump latency", lat, 1);
  endtask

  task automatic t_wrap;
    int lat;
    issue(3'd1, 2'd0, '0, 32'hFFFF_FFF8, '0, 4'd1, '0, lat);
    issue(3'd0, 2'd0, 32'h0000_0008, '0, '0, 4'd4, '0, lat);
    chk("R9 wrap", ip, 32'h0000_0004);
  endtask

  task automatic t_calls_returns;
    int lat;
    logic [31:0] ret1, ret2;
    ret1 = ip + 32'd5;
    issue(3'd3, 2'd2, 32'h0000_0020, '0, '0, 4'd5, '0, lat);
    chk("R5 call target", ip, ret1 + 32'h20);
    chk("R5 call sp", sp, 32'h0FC);
    chk("R5 pushed word", smem[6'd63], ret1);
    chk("R5 call latency", lat, 2);
    ret2 = ip + 32'd2;
    issue(3'd4, 2'd0, '0, 32'h0000_5000, '0, 4'd2, '0, lat);
    chk("R5 register call", ip, 32'h5000);
    chk("R5 second push", smem[6'd62], ret2);
    chk("R5 sp twice", sp, 32'h0F8);
    issue(3'd6, 2'd0, '0, '0, '0, 4'd1, 16'd0, lat);
    chk("R6 return ip", ip, ret2);
    chk("R6 return sp", sp, 32'h0FC);
    chk("R6 return latency", lat, 2);
    issue(3'd6, 2'd0, '0, '0, '0, 4'd1, 16'd8, lat);
    chk("R6 return pop ip", ip, ret1);
    chk("R6 return pop sp", sp, 32'h108);
    chk("R7 flags untouched", flags, 32'h2);
  endtask

  task automatic t_iret;
    int lat;
    poke(32'h108, 32'h0000_7000);
    poke(32'h10C, 32'h0000_0ACD);
    issue(3'd7, 2'd0, '0, '0, '0, 4'd1, 16'h40, lat);
    chk("R7 iret ip", ip, 32'h7000);
    chk("R7 iret flags", flags, 32'h0ACD);
    chk("R7 iret sp ignores pop", sp, 32'h110);
    chk("R7 iret latency", lat, 3);
  endtask

  task automatic t_stall;
    int lat;
    logic [31:0] ip0, sp0;
    stall_set = 3;
    ip0 = ip; sp0 = sp;
    @(negedge clk);
    op_kind = 3'd5; mem_target = 32'h0000_9000; insn_len = 4'd2; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // stray jump offered while busy must be ignored
    op_kind = 3'd1; reg_target = 32'hDEAD_0000;
    chk("R2 busy not ready", {31'd0, op_ready}, 32'd0);
    @(negedge clk);
    op_valid = 1'b0;
    lat = 2;
    for (int i = 0; i < 2; i++) begin
      chk("R8 request held", stk_addr, sp0 - 32'd4);
      chk("R8 ip frozen", ip, ip0);
      chk("R8 sp frozen", sp, sp0);
      @(negedge clk);
      lat++;
    end
    while (done !== 1'b1 && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk("R8 stalled call latency", lat, 5);
    chk("R2 R8 call target", ip, 32'h9000);
    chk("R8 stalled push", smem[(sp0[7:2] - 6'd1)], ip0 + 32'd2);
    chk("R8 sp after stall", sp, sp0 - 32'd4);
    @(negedge clk);
    chk("R2 stray op ignored", ip, 32'h9000);
    stall_set = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rel_jumps();
    t_indirect();
    t_wrap();
    t_calls_returns();
    t_iret();
    t_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule